// File: doc/BRIEF.md
# Load-Use Interlock and Delayed-Branch Controller

This block is the hazard and control-flow controller for a five-stage pipeline that has result bypasses. It keeps a small control record for the instructions in RD, ALU and MEM. Each record holds the instruction class, the source register numbers and their use flags, the destination, and the write flag. From these records it decides each cycle whether the front of the pipeline must wait, whether a bubble enters ALU, and where the next fetch address comes from.

Bypassing cannot help a load. Its data exists only once the load reaches MEM, so an instruction in RD that reads the register being loaded must wait one cycle. During that cycle the block holds the PC and the RD instruction, drops the fetch result and sends an empty instruction into ALU. After that the MEM-stage bypass carries the value.

Branches resolve in ALU. The datapath supplies the taken flag and the target. The instruction already sitting in RD at that moment is the single architectural delay slot, and it always goes on to execute. On a taken branch, the instruction fetched behind the slot is wrong-path work. It is replaced by a no-op as it enters RD, and the next fetch address is the target.

Top module: `pipe_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, every stage class output reads 0 (no-op), pc_sel_o is 0 (sequential), and front_stall_o, alu_bubble_o and fetch_squash_o are 0.
- R2: A load-use hit exists when ALU holds a load (class 2) with its write flag set and a nonzero destination, and that destination equals an RD source whose use flag is set. On a hit, front_stall_o and alu_bubble_o are 1 and pc_sel_o is 1 (hold), so pc_next_o equals pc_cur.
- R3: After a hit cycle, RD still holds the same instruction and ALU holds a no-op with no write flag. The hit therefore clears after exactly one cycle, and the waiting instruction moves on in the next cycle.
- R4: No stall occurs when the ALU instruction is not a load, when the load's destination is register 0, or when the only matching RD source field has its use flag clear.
- R5: When ALU holds a branch (class 4) and br_taken is 1, pc_sel_o is 2 (target) and pc_next_o equals br_target.
- R6: On a taken branch, fetch_squash_o is 1. In the next cycle RD holds a no-op, and ALU holds the instruction that was in RD, which is the delay slot.
- R7: br_taken has no effect unless ALU holds a branch: pc_sel_o stays 0 and no squash occurs.
- R8: With no hazard, records advance one stage per cycle. The class of the instruction in MEM equals the class in ALU one cycle earlier.
- R9: With no hazard and no branch taken, pc_sel_o is 0 and pc_next_o equals pc_cur plus PC_STEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_cls | input | 3 | Class of the fetched instruction entering RD (0 nop, 1 alu, 2 load, 3 store, 4 branch) |
| in_src1 | input | 5 | First source register number |
| in_src2 | input | 5 | Second source register number |
| in_use1 | input | 1 | First source is read |
| in_use2 | input | 1 | Second source is read |
| in_dest | input | 5 | Destination register number |
| in_wen | input | 1 | Instruction writes its destination |
| br_taken | input | 1 | Branch outcome computed for the ALU-stage instruction |
| br_target | input | PC_W | Branch target computed in ALU |
| pc_cur | input | PC_W | Current fetch address |
| pc_sel_o | output | 2 | Next-PC source: 0 sequential, 1 hold, 2 target |
| pc_next_o | output | PC_W | Next fetch address |
| front_stall_o | output | 1 | Hold PC and RD, drop the fetch result |
| alu_bubble_o | output | 1 | A no-op enters ALU at the next edge |
| fetch_squash_o | output | 1 | The fetched instruction is turned into a no-op |
| rd_cls_o | output | 3 | Class of the instruction in RD |
| alu_cls_o | output | 3 | Class of the instruction in ALU |
| mem_cls_o | output | 3 | Class of the instruction in MEM |

## Verification
The delay-slot case is the hardest to reach from the ports. The bench must first steer a branch into RD and then into ALU with a real instruction behind it in RD and another one arriving from fetch. Only then, in the single cycle when ALU holds the branch, can it raise br_taken. The stimulus table does this by sending a branch, a slot instruction and a wrong-path instruction back to back. It then checks, one cycle later, that the slot sits in ALU and that RD is empty. A second case runs a load whose consumer has itself just come out of a stall. This shows that the hold releases after one cycle and that the refetched instruction is accepted.

// File: rtl/pipe_ctrl_pkg.sv
package pipe_ctrl_pkg;

  localparam int REG_W = 5;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CL_NOP    = 3'd0,
    CL_ALU    = 3'd1,
    CL_LOAD   = 3'd2,
    CL_STORE  = 3'd3,
    CL_BRANCH = 3'd4
  } iclass_e;

  typedef enum logic [1:0] {
    PCS_SEQ    = 2'd0,
    PCS_HOLD   = 2'd1,
    PCS_TARGET = 2'd2
  } pc_sel_e;

  typedef struct packed {
    iclass_e          cls;
    logic [REG_W-1:0] src1;
    logic [REG_W-1:0] src2;
    logic             use1;
    logic             use2;
    logic [REG_W-1:0] dest;
    logic             wen;
  } ctl_rec_t;

  // An empty slot: no class, no reads, no write.
  function automatic ctl_rec_t empty_rec();
    ctl_rec_t r;
    r = '0;
    return r;
  endfunction

  // True when the record really reads register x.
  function automatic logic reads_reg(ctl_rec_t r, logic [REG_W-1:0] x);
    return (r.cls != CL_NOP) &&
           ((r.use1 && (r.src1 == x)) || (r.use2 && (r.src2 == x)));
  endfunction

  // True when the record produces a value a consumer could wait on.
  function automatic logic makes_value(ctl_rec_t r);
    return r.wen && (r.dest != '0);
  endfunction

endpackage

// File: rtl/pc_ctrl_hazard.sv
module pc_ctrl_hazard
  import pipe_ctrl_pkg::*;
(
  input  ctl_rec_t rd_rec,
  input  iclass_e  alu_cls,
  input  logic [REG_W-1:0] alu_dest,
  input  logic     alu_wen,
  output logic     load_use_o
);

  ctl_rec_t alu_view;
  logic     alu_is_load;

  always_comb begin
    alu_view      = empty_rec();
    alu_view.cls  = alu_cls;
    alu_view.dest = alu_dest;
    alu_view.wen  = alu_wen;
  end

  assign alu_is_load = (alu_cls == CL_LOAD);
  assign load_use_o  = alu_is_load && makes_value(alu_view) &&
                       reads_reg(rd_rec, alu_dest);

endmodule

// File: rtl/pc_ctrl_branch.sv
module pc_ctrl_branch
  import pipe_ctrl_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  iclass_e         alu_cls,
  input  logic            br_taken,
  input  logic            load_use,
  input  logic [PC_W-1:0] pc_cur,
  input  logic [PC_W-1:0] br_target,
  output logic            taken_o,
  output pc_sel_e         pc_sel_o,
  output logic [PC_W-1:0] pc_next_o
);

  localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

  function automatic logic [PC_W-1:0] seq_pc(logic [PC_W-1:0] pc);
    return pc + STEP_V;
  endfunction

  function automatic logic [PC_W-1:0] pick_pc(pc_sel_e s, logic [PC_W-1:0] pc,
                                               logic [PC_W-1:0] tgt);
    case (s)
      PCS_HOLD:   return pc;
      PCS_TARGET: return tgt;
      default:    return seq_pc(pc);
    endcase
  endfunction

  assign taken_o = (alu_cls == CL_BRANCH) && br_taken;

  // Redirect wins over hold: the held RD instruction is then the delay slot.
  always_comb begin
    if (taken_o)       pc_sel_o = PCS_TARGET;
    else if (load_use) pc_sel_o = PCS_HOLD;
    else               pc_sel_o = PCS_SEQ;
  end

  assign pc_next_o = pick_pc(pc_sel_o, pc_cur, br_target);

endmodule

// File: rtl/pc_ctrl_stages.sv
module pc_ctrl_stages
  import pipe_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ctl_rec_t in_rec,
  input  logic     hold_front,
  input  logic     squash_fetch,
  output ctl_rec_t rd_q,
  output ctl_rec_t alu_q,
  output iclass_e  mem_cls_o
);

  ctl_rec_t mem_q;
  ctl_rec_t rd_n;
  ctl_rec_t alu_n;

  always_comb begin
    if (hold_front)        rd_n = rd_q;
    else if (squash_fetch) rd_n = empty_rec();
    else                   rd_n = in_rec;
    alu_n = hold_front ? empty_rec() : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= empty_rec();
      alu_q <= empty_rec();
      mem_q <= empty_rec();
    end else begin
      rd_q  <= rd_n;
      alu_q <= alu_n;
      mem_q <= alu_q;
    end
  end

  assign mem_cls_o = mem_q.cls;

  assert_bubble_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_front |=> (alu_q.cls == CL_NOP) && !alu_q.wen);

  assert_squash_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_fetch && !hold_front) |=> (rd_q.cls == CL_NOP) && !rd_q.wen);

  assert_mem_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> mem_q == $past(alu_q));

endmodule

// File: rtl/pipe_ctrl.sv
module pipe_ctrl
  import pipe_ctrl_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      in_cls,
  input  logic [4:0]      in_src1,
  input  logic [4:0]      in_src2,
  input  logic            in_use1,
  input  logic            in_use2,
  input  logic [4:0]      in_dest,
  input  logic            in_wen,
  input  logic            br_taken,
  input  logic [PC_W-1:0] br_target,
  input  logic [PC_W-1:0] pc_cur,
  output logic [1:0]      pc_sel_o,
  output logic [PC_W-1:0] pc_next_o,
  output logic            front_stall_o,
  output logic            alu_bubble_o,
  output logic            fetch_squash_o,
  output logic [2:0]      rd_cls_o,
  output logic [2:0]      alu_cls_o,
  output logic [2:0]      mem_cls_o
);

  ctl_rec_t in_rec;
  ctl_rec_t rd_q;
  ctl_rec_t alu_q;
  iclass_e  mem_cls;
  logic     load_use;
  logic     taken;
  pc_sel_e  pc_sel;

  always_comb begin
    in_rec      = empty_rec();
    in_rec.cls  = iclass_e'(in_cls);
    in_rec.src1 = in_src1;
    in_rec.src2 = in_src2;
    in_rec.use1 = in_use1;
    in_rec.use2 = in_use2;
    in_rec.dest = in_dest;
    in_rec.wen  = in_wen;
  end

  pc_ctrl_hazard u_hazard (
    .rd_rec     (rd_q),
    .alu_cls    (alu_q.cls),
    .alu_dest   (alu_q.dest),
    .alu_wen    (alu_q.wen),
    .load_use_o (load_use)
  );

  pc_ctrl_branch #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_branch (
    .alu_cls   (alu_q.cls),
    .br_taken  (br_taken),
    .load_use  (load_use),
    .pc_cur    (pc_cur),
    .br_target (br_target),
    .taken_o   (taken),
    .pc_sel_o  (pc_sel),
    .pc_next_o (pc_next_o)
  );

  pc_ctrl_stages u_stages (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_rec       (in_rec),
    .hold_front   (load_use),
    .squash_fetch (taken),
    .rd_q         (rd_q),
    .alu_q        (alu_q),
    .mem_cls_o    (mem_cls)
  );

  assign pc_sel_o       = pc_sel;
  assign front_stall_o  = load_use;
  assign alu_bubble_o   = load_use;
  assign fetch_squash_o = taken;
  assign rd_cls_o       = rd_q.cls;
  assign alu_cls_o      = alu_q.cls;
  assign mem_cls_o      = mem_cls;

  assert_hazards_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_use, taken}));

  assert_single_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_use |=> !load_use);

  assert_rd_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_use |=> rd_q == $past(rd_q));

  assert_slot_advances_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !load_use) |=> alu_q == $past(rd_q));

  assert_redirect_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_sel == PCS_TARGET) |-> (pc_next_o == br_target) && fetch_squash_o);

endmodule

// File: tb/pipe_ctrl_tb_top.sv
module pipe_ctrl_tb_top;

  localparam int PC_W = 32;
  localparam int NV   = 20;
  localparam logic [PC_W-1:0] TGT = 32'h0000_0800;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      in_cls = '0;
  logic [4:0]      in_src1 = '0, in_src2 = '0, in_dest = '0;
  logic            in_use1 = 1'b0, in_use2 = 1'b0, in_wen = 1'b0;
  logic            br_taken = 1'b0;
  logic [PC_W-1:0] br_target = TGT;
  logic [PC_W-1:0] pc_cur = '0;
  logic [1:0]      pc_sel_o;
  logic [PC_W-1:0] pc_next_o;
  logic            front_stall_o, alu_bubble_o, fetch_squash_o;
  logic [2:0]      rd_cls_o, alu_cls_o, mem_cls_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pipe_ctrl #(.PC_W(PC_W), .PC_STEP(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_cls(in_cls), .in_src1(in_src1), .in_src2(in_src2),
    .in_use1(in_use1), .in_use2(in_use2), .in_dest(in_dest), .in_wen(in_wen),
    .br_taken(br_taken), .br_target(br_target), .pc_cur(pc_cur),
    .pc_sel_o(pc_sel_o), .pc_next_o(pc_next_o), .front_stall_o(front_stall_o),
    .alu_bubble_o(alu_bubble_o), .fetch_squash_o(fetch_squash_o),
    .rd_cls_o(rd_cls_o), .alu_cls_o(alu_cls_o), .mem_cls_o(mem_cls_o)
  );

  // {cls, src1, src2, dest, taken | exp sel, exp stall, exp squash, exp rd cls, exp alu cls}
  localparam logic [28:0] TBL [NV] = '{
    {3'd2, 5'd1, 5'd0, 5'd4,  1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 3'd0},
    {3'd1, 5'd4, 5'd2, 5'd6,  1'b0, 2'd0, 1'b0, 1'b0, 3'd2, 3'd0},
    {3'd1, 5'd7, 5'd8, 5'd9,  1'b0, 2'd1, 1'b1, 1'b0, 3'd1, 3'd2},
    {3'd1, 5'd7, 5'd8, 5'd9,  1'b0, 2'd0, 1'b0, 1'b0, 3'd1, 3'd0},
    {3'd2, 5'd1, 5'd0, 5'd3,  1'b0, 2'd0, 1'b0, 1'b0, 3'd1, 3'd1},
    {3'd1, 5'd5, 5'd3, 5'd10, 1'b0, 2'd0, 1'b0, 1'b0, 3'd2, 3'd1},
    {3'd4, 5'd1, 5'd2, 5'd0,  1'b0, 2'd1, 1'b1, 1'b0, 3'd1, 3'd2},
    {3'd4, 5'd1, 5'd2, 5'd0,  1'b0, 2'd0, 1'b0, 1'b0, 3'd1, 3'd0},
    {3'd1, 5'd1, 5'd1, 5'd11, 1'b0, 2'd0, 1'b0, 1'b0, 3'd4, 3'd1},
    {3'd1, 5'd1, 5'd1, 5'd12, 1'b1, 2'd2, 1'b0, 1'b1, 3'd1, 3'd4},
    {3'd1, 5'd2, 5'd2, 5'd13, 1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 3'd1},
    {3'd2, 5'd1, 5'd0, 5'd0,  1'b0, 2'd0, 1'b0, 1'b0, 3'd1, 3'd0},
    {3'd1, 5'd0, 5'd0, 5'd14, 1'b0, 2'd0, 1'b0, 1'b0, 3'd2, 3'd1},
    {3'd4, 5'd3, 5'd3, 5'd0,  1'b1, 2'd0, 1'b0, 1'b0, 3'd1, 3'd2},
    {3'd1, 5'd1, 5'd1, 5'd15, 1'b0, 2'd0, 1'b0, 1'b0, 3'd4, 3'd1},
    {3'd1, 5'd1, 5'd1, 5'd16, 1'b0, 2'd0, 1'b0, 1'b0, 3'd1, 3'd4},
    {3'd2, 5'd1, 5'd0, 5'd7,  1'b0, 2'd0, 1'b0, 1'b0, 3'd1, 3'd1},
    {3'd2, 5'd2, 5'd7, 5'd8,  1'b0, 2'd0, 1'b0, 1'b0, 3'd2, 3'd1},
    {3'd0, 5'd0, 5'd0, 5'd0,  1'b0, 2'd0, 1'b0, 1'b0, 3'd2, 3'd2},
    {3'd0, 5'd0, 5'd0, 5'd0,  1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 3'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic [4:0] s1, input logic [4:0] s2,
                       input logic [4:0] d, input logic tk);
    in_cls   = c;
    in_src1  = s1;
    in_src2  = s2;
    in_dest  = d;
    in_use1  = (c != 3'd0);
    in_use2  = (c == 3'd1) || (c == 3'd3) || (c == 3'd4);
    in_wen   = (c == 3'd1) || (c == 3'd2);
    br_taken = tk;
  endtask

  function automatic logic [31:0] exp_pc(input logic [1:0] sel, input logic [31:0] pc);
    if (sel == 2'd1) return pc;
    if (sel == 2'd2) return TGT;
    return pc + 32'd4;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    logic [2:0] prev_alu;
    drive(3'd0, 5'd0, 5'd0, 5'd0, 1'b1);
    repeat (2) @(negedge clk);
    #2;
    // R1 / R7: in reset, a raised br_taken does nothing
    chk("R1 sel in reset", pc_sel_o, 2'd0);
    chk("R1 stall in reset", front_stall_o, 1'b0);
    chk("R1 squash in reset", fetch_squash_o, 1'b0);
    chk("R1 rd cls in reset", rd_cls_o, 3'd0);
    chk("R1 mem cls in reset", mem_cls_o, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    prev_alu = 3'd0;
    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = TBL[i];
      pc_cur = 32'h100 + 32'(i) * 32'd4;
      drive(v[28:26], v[25:21], v[20:16], v[15:11], v[10]);
      #3;
      chk($sformatf("R2/R5/R7/R9 pc_sel vec %0d", i), pc_sel_o, v[9:8]);
      chk($sformatf("R5/R9 pc_next vec %0d", i), pc_next_o, exp_pc(v[9:8], pc_cur));
      chk($sformatf("R2/R4 stall vec %0d", i), front_stall_o, v[7]);
      chk($sformatf("R2 bubble vec %0d", i), alu_bubble_o, v[7]);
      chk($sformatf("R6 squash vec %0d", i), fetch_squash_o, v[6]);
      chk($sformatf("R3/R6 rd cls vec %0d", i), rd_cls_o, v[5:3]);
      chk($sformatf("R3/R6 alu cls vec %0d", i), alu_cls_o, v[2:0]);
      chk($sformatf("R8 mem cls vec %0d", i), mem_cls_o, prev_alu);
      prev_alu = v[2:0];
      @(negedge clk);
    end

    // Directed: build a hit, then reset in the middle of it (R2, R1)
    drive(3'd2, 5'd1, 5'd0, 5'd5, 1'b0);
    @(negedge clk);
    drive(3'd1, 5'd5, 5'd5, 5'd6, 1'b0);
    @(negedge clk);
    drive(3'd0, 5'd0, 5'd0, 5'd0, 1'b0);
    #2;
    chk("R2 hit on both sources", front_stall_o, 1'b1);
    chk("R2 hold pc", pc_next_o, pc_cur);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears stall", front_stall_o, 1'b0);
    chk("R1 async reset rd", rd_cls_o, 3'd0);
    chk("R1 async reset alu", alu_cls_o, 3'd0);
    chk("R1 async reset sel", pc_sel_o, 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R7: taken flag with an empty ALU stage
    drive(3'd1, 5'd1, 5'd2, 5'd3, 1'b1);
    #2;
    chk("R7 taken ignored sel", pc_sel_o, 2'd0);
    chk("R7 taken ignored squash", fetch_squash_o, 1'b0);
    @(negedge clk);
    drive(3'd0, 5'd0, 5'd0, 5'd0, 1'b0);
    #2;
    chk("R7 fetched instruction kept", rd_cls_o, 3'd1);
    @(negedge clk);
    finish_run();
  end

endmodule